// File: doc/BRIEF.md
# Receive FIFO with Hysteresis Flow Control

This block sits between a serial receiver and the register side of a serial port. Each byte the receiver finishes is pushed into a first-in first-out store. The bus side drains the store one byte at a time. The block reports how many bytes are held and raises a set of status flags. It also drives the request-to-send (RTS) pin from two occupancy thresholds, so that the remote transmitter is paused before the store overflows.

The RTS pin follows a hysteresis rule. It goes high, which tells the peer to stop, once the fill level reaches the upper threshold. It goes low, which invites more data, once the level drops to the lower threshold. Between the two thresholds it keeps its last value. This control is active only while the flow-control enable is set, and only while the lower threshold does not exceed the upper one.

The push side cannot be stalled, because a serial line cannot be held back in mid-frame. `rx_ready` is advisory: a byte offered while it is low is lost and the overrun flag records the loss. The pop side follows valid/ready rules. A byte leaves when `rd_valid` and `rd_ready` are both high in the same cycle. If `rd_ready` is raised while `rd_valid` is low, no byte leaves and the pointer-error flag is set.

Top module: `rx_fifo_rts`

## Requirements
- R1: After reset, `level` is 0, `flag_empty` is 1, `rd_valid` is 0, `rx_ready` is 1, `rts` is 0, and `flag_ovr` and `flag_ptr_err` are both 0.
- R2: Bytes leave in the order they arrived. `level` rises by one for each accepted push and falls by one for each accepted pop, and a push and a pop in the same cycle leave it unchanged. `rd_data` always shows the oldest byte held.
- R3: When `level` equals DEPTH, `flag_full` is 1 and `rx_ready` is 0. A byte offered at that point is dropped and `flag_ovr` is set. The flag stays set until a clear.
- R4: Raising `rd_ready` while the store is empty leaves `level` at 0 and sets `flag_ptr_err`. The flag stays set until a clear, and `rd_data` then shows stale content.
- R5: With flow control on and `thr_lo <= thr_hi`, `rts` is 1 from the same clock edge at which `level` reaches `thr_hi` or more.
- R6: With flow control on and `thr_lo <= thr_hi`, `rts` is 0 from the edge at which `level` falls to `thr_lo` or less, as long as `level` is also below `thr_hi`.
- R7: With flow control on and a legal setting, `rts` keeps its value while `level` stays strictly between the two thresholds.
- R8: While `flow_en` is 0, `rts` is 0 at the next edge and stays 0 whatever the level.
- R9: While `thr_lo > thr_hi`, `rts` keeps its current value. After a legal setting is written, the hysteresis rule applies again from the next edge.
- R10: `rx_avail` depends on `rdy_mode`. Mode 0 needs `level >= 1`, mode 1 needs `level >= 2`, mode 2 needs `level >= 4`, and mode 3 behaves like mode 0.
- R11: `flag_hi` is 1 exactly when `level >= thr_hi`, and `flag_lo` is 1 exactly when `level <= thr_lo`.
- R12: `clr` takes priority over any push or pop in the same cycle. After that edge, `level` is 0, both sticky flags are 0, and `rts` is 0 unless `thr_hi` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the store and of the sticky flags |
| flow_en | input | 1 | Enables threshold control of RTS |
| thr_hi | input | THR_W | Upper threshold (stop the peer) |
| thr_lo | input | THR_W | Lower threshold (resume the peer) |
| rdy_mode | input | 2 | Receive-ready mode: 0 one byte, 1 two bytes, 2 four bytes |
| rx_valid | input | 1 | Receiver offers a byte this cycle |
| rx_data | input | DATA_W | Received byte |
| rx_ready | output | 1 | Store not full (advisory) |
| rd_valid | output | 1 | Store holds at least one byte |
| rd_ready | input | 1 | Bus side takes the head byte |
| rd_data | output | DATA_W | Oldest byte held |
| level | output | LVL_W | Current fill level |
| rx_avail | output | 1 | Receive-ready indication per `rdy_mode` |
| flag_empty | output | 1 | Level is 0 |
| flag_full | output | 1 | Level is DEPTH |
| flag_hi | output | 1 | Level at or above `thr_hi` |
| flag_lo | output | 1 | Level at or below `thr_lo` |
| flag_ovr | output | 1 | Sticky: a byte was dropped while full |
| flag_ptr_err | output | 1 | Sticky: a pop was requested while empty |
| rts | output | 1 | Request-to-send pin level (1 = stop) |

## Verification
If a pointer or the occupancy counter drifts, the wrong byte appears on `rd_data` at the next pop, or `level` disagrees with the count of accepted transfers right after the edge that caused the error. A fault in the hysteresis state shows on `rts` at the first edge where the level sits at or crosses a threshold. A fault that flips `rts` between the thresholds shows at once as a change the rule forbids. Sticky-flag faults appear one edge after the full push or empty pop. The RTS module is fed the level the store will hold after the current edge, so a misaligned copy of that level leaves `rts` one cycle out of step with `level`. The stimulus table checks both signals at every edge so that such a slip is seen.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [1:0] {
    RDY_ONE  = 2'd0,
    RDY_TWO  = 2'd1,
    RDY_FOUR = 2'd2,
    RDY_RSVD = 2'd3
  } rdy_mode_e;

  function automatic int unsigned rdy_need(rdy_mode_e m);
    case (m)
      RDY_TWO:  return 2;
      RDY_FOUR: return 4;
      default:  return 1;
    endcase
  endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int LVL_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] head_data,
  output logic [LVL_W-1:0]  level,
  output logic [LVL_W-1:0]  level_nxt,
  output logic              full,
  output logic              empty,
  output logic              ovr,
  output logic              ptr_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  assign full      = (level == LVL_W'(DEPTH));
  assign empty     = (level == '0);
  assign do_push   = push_req && !full && !clr;
  assign do_pop    = pop_req && !empty && !clr;
  assign head_data = mem[rd_ptr];

  always_comb begin
    if (clr) level_nxt = '0;
    else     level_nxt = level + LVL_W'(do_push) - LVL_W'(do_pop);
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level   <= '0;
      ovr     <= 1'b0;
      ptr_err <= 1'b0;
    end else if (clr) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level   <= '0;
      ovr     <= 1'b0;
      ptr_err <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      level <= level_nxt;
      if (push_req && full)  ovr     <= 1'b1;
      if (pop_req  && empty) ptr_err <= 1'b1;
    end
  end

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_req && !clr) |=> (ovr && full));

  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !push_req && !clr) |=> (ptr_err && empty));

  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && !ovr && !ptr_err));

endmodule

// File: rtl/rxf_rts.sv
module rxf_rts #(
  parameter int LVL_W = 6,
  parameter int THR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flow_en,
  input  logic [THR_W-1:0] thr_hi,
  input  logic [THR_W-1:0] thr_lo,
  input  logic [LVL_W-1:0] lvl_nxt,
  output logic             rts
);
  localparam int CW = (LVL_W > THR_W) ? LVL_W : THR_W;

  logic [CW-1:0] lv, hi, lo;
  logic          legal;

  assign lv    = CW'(lvl_nxt);
  assign hi    = CW'(thr_hi);
  assign lo    = CW'(thr_lo);
  assign legal = (lo <= hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rts <= 1'b0;
    else if (!flow_en)     rts <= 1'b0;
    else if (legal) begin
      if (lv >= hi)        rts <= 1'b1;
      else if (lv <= lo)   rts <= 1'b0;
    end
  end

  assert_rts_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && legal && lv >= hi) |=> rts);

  assert_rts_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && legal && lv <= lo && lv < hi) |=> !rts);

  assert_rts_band_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && legal && lv > lo && lv < hi) |=> $stable(rts));

  assert_rts_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_en |=> !rts);

  assert_rts_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && !legal) |=> $stable(rts));

endmodule

// File: rtl/rxf_flags.sv
module rxf_flags
  import rxf_pkg::*;
#(
  parameter int LVL_W = 6,
  parameter int THR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [THR_W-1:0] thr_hi,
  input  logic [THR_W-1:0] thr_lo,
  input  rdy_mode_e        mode,
  output logic             avail,
  output logic             at_hi,
  output logic             at_lo
);
  localparam int CW = (LVL_W > THR_W) ? LVL_W : THR_W;

  logic [CW-1:0] lv;
  assign lv    = CW'(level);
  assign at_hi = (lv >= CW'(thr_hi));
  assign at_lo = (lv <= CW'(thr_lo));
  assign avail = (int'(level) >= int'(rdy_need(mode)));

  assert_avail_four_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RDY_FOUR && avail) |-> (level >= LVL_W'(4)));

  assert_avail_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RDY_ONE && level != '0) |-> avail);

endmodule

// File: rtl/rx_fifo_rts.sv
module rx_fifo_rts
  import rxf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int THR_W  = 6,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              flow_en,
  input  logic [THR_W-1:0]  thr_hi,
  input  logic [THR_W-1:0]  thr_lo,
  input  logic [1:0]        rdy_mode,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic [LVL_W-1:0]  level,
  output logic              rx_avail,
  output logic              flag_empty,
  output logic              flag_full,
  output logic              flag_hi,
  output logic              flag_lo,
  output logic              flag_ovr,
  output logic              flag_ptr_err,
  output logic              rts
);
  logic [LVL_W-1:0] level_nxt;

  rxf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push_req(rx_valid), .push_data(rx_data), .pop_req(rd_ready),
    .head_data(rd_data), .level(level), .level_nxt(level_nxt),
    .full(flag_full), .empty(flag_empty), .ovr(flag_ovr), .ptr_err(flag_ptr_err)
  );

  rxf_rts #(.LVL_W(LVL_W), .THR_W(THR_W)) u_rts (
    .clk(clk), .rst_n(rst_n), .flow_en(flow_en),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .lvl_nxt(level_nxt), .rts(rts)
  );

  rxf_flags #(.LVL_W(LVL_W), .THR_W(THR_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .level(level),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .mode(rdy_mode_e'(rdy_mode)),
    .avail(rx_avail), .at_hi(flag_hi), .at_lo(flag_lo)
  );

  assign rx_ready = !flag_full;
  assign rd_valid = !flag_empty;

  assert_ready_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_full |-> (!rx_ready && rd_valid));

endmodule

// File: tb/rx_fifo_rts_tb.sv
module rx_fifo_rts_tb_top;
  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0, flow_en = 1'b1;
  logic [5:0] thr_hi = 6'd6, thr_lo = 6'd2;
  logic [1:0] rdy_mode = 2'd0;
  logic       rx_valid = 1'b0, rd_ready = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_ready, rd_valid, rx_avail;
  logic [7:0] rd_data;
  logic [5:0] level;
  logic       flag_empty, flag_full, flag_hi, flag_lo, flag_ovr, flag_ptr_err, rts;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rx_fifo_rts dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .flow_en(flow_en),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .rdy_mode(rdy_mode),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .level(level), .rx_avail(rx_avail), .flag_empty(flag_empty),
    .flag_full(flag_full), .flag_hi(flag_hi), .flag_lo(flag_lo),
    .flag_ovr(flag_ovr), .flag_ptr_err(flag_ptr_err), .rts(rts)
  );

  // entry: [31:30] op (1 push, 2 pop, 3 both), [29:22] push byte,
  // [21:14] head byte expected before a pop, [13:8] level after, [7] rts after
  localparam logic [31:0] VEC [17] = '{
    {2'd1, 8'h11, 8'h00, 6'd1, 1'b0, 7'd0},
    {2'd1, 8'h22, 8'h00, 6'd2, 1'b0, 7'd0},
    {2'd1, 8'h33, 8'h00, 6'd3, 1'b0, 7'd0},
    {2'd1, 8'h44, 8'h00, 6'd4, 1'b0, 7'd0},
    {2'd1, 8'h55, 8'h00, 6'd5, 1'b0, 7'd0},
    {2'd1, 8'h66, 8'h00, 6'd6, 1'b1, 7'd0},
    {2'd1, 8'h77, 8'h00, 6'd7, 1'b1, 7'd0},
    {2'd2, 8'h00, 8'h11, 6'd6, 1'b1, 7'd0},
    {2'd2, 8'h00, 8'h22, 6'd5, 1'b1, 7'd0},
    {2'd2, 8'h00, 8'h33, 6'd4, 1'b1, 7'd0},
    {2'd3, 8'h88, 8'h44, 6'd4, 1'b1, 7'd0},
    {2'd2, 8'h00, 8'h55, 6'd3, 1'b1, 7'd0},
    {2'd2, 8'h00, 8'h66, 6'd2, 1'b0, 7'd0},
    {2'd1, 8'h99, 8'h00, 6'd3, 1'b0, 7'd0},
    {2'd2, 8'h00, 8'h77, 6'd2, 1'b0, 7'd0},
    {2'd2, 8'h00, 8'h88, 6'd1, 1'b0, 7'd0},
    {2'd2, 8'h00, 8'h99, 6'd0, 1'b0, 7'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a falling edge; applies inputs for exactly one rising edge
  task automatic step(input logic p, input logic [7:0] d, input logic q);
    rx_valid = p; rx_data = d; rd_ready = q;
    @(negedge clk);
    rx_valid = 1'b0; rd_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 level", level, 0);
    chk("R1 empty", flag_empty, 1);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 rx_ready", rx_ready, 1);
    chk("R1 rts", rts, 0);
    chk("R1 sticky", {flag_ovr, flag_ptr_err}, 0);

    // R2 R5 R6 R7: table walk, hi=6 lo=2
    for (int i = 0; i < 17; i++) begin
      logic [31:0] v;
      v = VEC[i];
      if (v[31]) chk("R2 head byte", rd_data, v[21:14]);
      step(v[30], v[29:22], v[31]);
      chk("R2 level", level, v[13:8]);
      chk("R5 R6 R7 rts", rts, v[7]);
    end

    // R10 R11 ready modes and threshold flags
    step(1'b1, 8'hC1, 1'b0);
    rdy_mode = 2'd0; #1 chk("R10 mode0 lvl1", rx_avail, 1);
    rdy_mode = 2'd1; #1 chk("R10 mode1 lvl1", rx_avail, 0);
    step(1'b1, 8'hC2, 1'b0);
    #1 chk("R10 mode1 lvl2", rx_avail, 1);
    chk("R11 flag_lo at lo", flag_lo, 1);
    rdy_mode = 2'd2; #1 chk("R10 mode2 lvl2", rx_avail, 0);
    @(negedge clk);
    step(1'b1, 8'hC3, 1'b0);
    step(1'b1, 8'hC4, 1'b0);
    chk("R10 mode2 lvl4", rx_avail, 1);
    chk("R11 flags mid", {flag_hi, flag_lo}, 0);
    rdy_mode = 2'd3; #1 chk("R10 mode3 lvl4", rx_avail, 1);
    @(negedge clk);

    // R3 fill and overrun
    for (int i = 0; i < 28; i++) step(1'b1, 8'(8'h10 + i), 1'b0);
    chk("R3 level full", level, DEPTH);
    chk("R3 full ready", {flag_full, rx_ready}, 2'b10);
    chk("R11 flag_hi", flag_hi, 1);
    chk("R5 rts full", rts, 1);
    step(1'b1, 8'hEE, 1'b0);
    chk("R3 ovr", flag_ovr, 1);
    chk("R3 level held", level, DEPTH);
    bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      int e;
      e = (i < 4) ? (8'hC1 + i) : (8'h10 + i - 4);
      if (rd_data != 8'(e)) bad++;
      step(1'b0, 8'h00, 1'b1);
    end
    chk("R2 R3 drain order", bad, 0);
    chk("R6 rts drained", rts, 0);
    chk("R3 ovr sticky", flag_ovr, 1);

    // R4 pop when empty
    step(1'b0, 8'h00, 1'b1);
    chk("R4 ptr_err", flag_ptr_err, 1);
    chk("R4 level", level, 0);
    chk("R4 rd_valid", rd_valid, 0);

    // R12 clear beats push
    clr = 1'b1;
    step(1'b1, 8'h5A, 1'b0);
    clr = 1'b0;
    chk("R12 level", level, 0);
    chk("R12 sticky", {flag_ovr, flag_ptr_err}, 0);
    chk("R12 rts", rts, 0);

    // R8 flow control off
    flow_en = 1'b0;
    for (int i = 0; i < 8; i++) step(1'b1, 8'(i), 1'b0);
    chk("R8 level", level, 8);
    chk("R8 rts off", rts, 0);
    flow_en = 1'b1;
    step(1'b0, 8'h00, 1'b0);
    chk("R5 rts after enable", rts, 1);

    // R9 illegal thresholds hold RTS
    thr_lo = 6'd10; thr_hi = 6'd5;
    for (int i = 0; i < 7; i++) step(1'b0, 8'h00, 1'b1);
    chk("R9 level", level, 1);
    chk("R9 rts held", rts, 1);
    thr_lo = 6'd2; thr_hi = 6'd6;
    step(1'b0, 8'h00, 1'b0);
    chk("R9 rts after legal", rts, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule